// File: doc/BRIEF.md
# 16-to-32 Bit Bus Width Upsizer

This block lets a bus master with a 16-bit data path reach a slave bus that is 32 bits wide. Every master request turns into exactly one 32-bit cycle on the slave side. There is no burst handling, merging or caching, because the data in front of the master is assumed to be cached already. The master address is a halfword address. Its bit 1 chooses whether the upper or the lower half of the 32-bit word is involved.

On a write, the master halfword appears in both halves of the outgoing word. The four byte-lane enables are then set so that only the two lanes of the chosen half are written. On a read, the whole 32-bit word is fetched and the half selected by address bit 1 is returned. The cycle, strobe and write-enable signals go forward unchanged. Acknowledge and error come back unchanged. The block is purely combinational, so it adds no cycle of latency.

Top module: `wb_upsizer16`

## Requirements
- R1: `sAdr` equals the master halfword address with bits 1:0 forced to zero. Bits AW-1:2 are copied from `mAdr[AW-1:2]`.
- R2: `sDatW` carries `mDatW` in both halves: bits 31:16 and bits 15:0 are each equal to `mDatW`.
- R3: When `mAdr[1]` is 0, `sSel` is `{2'b00, mSel}`. When `mAdr[1]` is 1, `sSel` is `{mSel, 2'b00}`. In both cases `mSel[0]` drives the lower lane of the chosen half.
- R4: When `mAdr[1]` is 0, `mDatR` equals `sDatR[15:0]`. When `mAdr[1]` is 1, `mDatR` equals `sDatR[31:16]`. The other half is discarded.
- R5: `sCyc`, `sStb` and `sWe` equal `mCyc`, `mStb` and `mWe` in the same cycle.
- R6: `mAck` and `mErr` equal `sAck` and `sErr` in the same cycle.
- R7: `sSel` never enables a lane in both halves at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mAdr | input | AW-1 | Master halfword address, bits AW-1:1 |
| mDatW | input | 16 | Master write data |
| mDatR | output | 16 | Master read data |
| mSel | input | 2 | Master byte enables |
| mWe | input | 1 | Master write enable |
| mCyc | input | 1 | Master bus cycle |
| mStb | input | 1 | Master strobe |
| mAck | output | 1 | Acknowledge to master |
| mErr | output | 1 | Error to master |
| sAdr | output | AW | Slave word address, bits 1:0 zero |
| sDatW | output | 32 | Slave write data |
| sDatR | input | 32 | Slave read data |
| sSel | output | 4 | Slave byte enables |
| sWe | output | 1 | Slave write enable |
| sCyc | output | 1 | Slave bus cycle |
| sStb | output | 1 | Slave strobe |
| sAck | input | 1 | Acknowledge from slave |
| sErr | input | 1 | Error from slave |

## Verification
Every result of this block is combinational, so each output is due in the same cycle as the input that causes it. There are zero cycles of latency in both directions. The bench applies each input pattern one nanosecond after a rising clock edge. It samples the outputs two nanoseconds later, still inside the same cycle and away from any edge. It compares them with values that bench functions compute from the requirements. Random patterns are mixed with directed cases for both address halves, both mask extremes, idle bus, and error without acknowledge.

// File: rtl/wb_upsizer16_pkg.sv
package wb_upsizer16_pkg;
  localparam int unsigned MST_DW = 16;
  localparam int unsigned SLV_DW = 2 * MST_DW;
  localparam int unsigned MST_SW = MST_DW / 8;
  localparam int unsigned SLV_SW = SLV_DW / 8;

  // Strobes from control to datapath: which half carries the transfer.
  typedef struct packed {
    logic useHi;
    logic useLo;
  } laneStrobe_t;
endpackage

// File: rtl/wb_upsizer16_ctrl.sv
module wb_upsizer16_ctrl
  import wb_upsizer16_pkg::*;
(
  input  logic        halfSel,
  input  logic        mWe,
  input  logic        mCyc,
  input  logic        mStb,
  input  logic        sAck,
  input  logic        sErr,
  output logic        sWe,
  output logic        sCyc,
  output logic        sStb,
  output logic        mAck,
  output logic        mErr,
  output laneStrobe_t laneStb
);
  always_comb begin
    laneStb.useHi = halfSel;
    laneStb.useLo = ~halfSel;
  end

  // Handshake is a straight pass-through in both directions.
  assign sWe  = mWe;
  assign sCyc = mCyc;
  assign sStb = mStb;
  assign mAck = sAck;
  assign mErr = sErr;
endmodule

// File: rtl/wb_upsizer16_dp.sv
module wb_upsizer16_dp
  import wb_upsizer16_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:2]     wordAdr,
  input  logic [MST_DW-1:0] mDatW,
  input  logic [MST_SW-1:0] mSel,
  input  logic [SLV_DW-1:0] sDatR,
  input  laneStrobe_t       laneStb,
  output logic [AW-1:0]     sAdr,
  output logic [SLV_DW-1:0] sDatW,
  output logic [SLV_SW-1:0] sSel,
  output logic [MST_DW-1:0] mDatR
);
  localparam int unsigned HALVES = SLV_DW / MST_DW;

  logic [HALVES-1:0] halfOn;
  assign halfOn = {laneStb.useHi, laneStb.useLo};

  assign sAdr = {wordAdr, 2'b00};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign sDatW[h*MST_DW +: MST_DW] = mDatW;
    assign sSel[h*MST_SW +: MST_SW]  = halfOn[h] ? mSel : '0;
  end

  assign mDatR = laneStb.useHi ? sDatR[SLV_DW-1:MST_DW] : sDatR[MST_DW-1:0];
endmodule

// File: rtl/wb_upsizer16.sv
module wb_upsizer16
  import wb_upsizer16_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:1]     mAdr,
  input  logic [MST_DW-1:0] mDatW,
  output logic [MST_DW-1:0] mDatR,
  input  logic [MST_SW-1:0] mSel,
  input  logic              mWe,
  input  logic              mCyc,
  input  logic              mStb,
  output logic              mAck,
  output logic              mErr,
  output logic [AW-1:0]     sAdr,
  output logic [SLV_DW-1:0] sDatW,
  input  logic [SLV_DW-1:0] sDatR,
  output logic [SLV_SW-1:0] sSel,
  output logic              sWe,
  output logic              sCyc,
  output logic              sStb,
  input  logic              sAck,
  input  logic              sErr
);
  laneStrobe_t laneStb;

  wb_upsizer16_ctrl u_ctrl (
    .halfSel (mAdr[1]),
    .mWe     (mWe),
    .mCyc    (mCyc),
    .mStb    (mStb),
    .sAck    (sAck),
    .sErr    (sErr),
    .sWe     (sWe),
    .sCyc    (sCyc),
    .sStb    (sStb),
    .mAck    (mAck),
    .mErr    (mErr),
    .laneStb (laneStb)
  );

  wb_upsizer16_dp #(.AW(AW)) u_dp (
    .wordAdr (mAdr[AW-1:2]),
    .mDatW   (mDatW),
    .mSel    (mSel),
    .sDatR   (sDatR),
    .laneStb (laneStb),
    .sAdr    (sAdr),
    .sDatW   (sDatW),
    .sSel    (sSel),
    .mDatR   (mDatR)
  );
endmodule

// File: rtl/wb_upsizer16_chk.sv
module wb_upsizer16_chk #(
  parameter int unsigned AW = 32
) (
  input logic [AW-1:1] mAdr,
  input logic [15:0]   mDatW,
  input logic [15:0]   mDatR,
  input logic [1:0]    mSel,
  input logic          mWe,
  input logic          mCyc,
  input logic          mStb,
  input logic          mAck,
  input logic          mErr,
  input logic [AW-1:0] sAdr,
  input logic [31:0]   sDatW,
  input logic [31:0]   sDatR,
  input logic [3:0]    sSel,
  input logic          sWe,
  input logic          sCyc,
  input logic          sStb,
  input logic          sAck,
  input logic          sErr
);
  always_comb begin
    AST_ADR_ALIGNED: assert (sAdr[1:0] == 2'b00 && sAdr[AW-1:2] == mAdr[AW-1:2]); // R1
    AST_DATW_MIRROR: assert (sDatW[31:16] == mDatW && sDatW[15:0] == mDatW); // R2
    AST_SEL_STEER: assert ((mAdr[1] ? sSel[3:2] : sSel[1:0]) == mSel); // R3
    AST_DATR_PICK: assert (mDatR == (mAdr[1] ? sDatR[31:16] : sDatR[15:0])); // R4
    AST_REQ_THRU: assert (sCyc == mCyc && sStb == mStb && sWe == mWe); // R5
    AST_RSP_THRU: assert (mAck == sAck && mErr == sErr); // R6
    AST_ONE_HALF: assert (!((|sSel[3:2]) && (|sSel[1:0]))); // R7
  end
endmodule

bind wb_upsizer16 wb_upsizer16_chk #(.AW(AW)) chk_i (.*);

// File: tb/wb_upsizer16_tb_top.sv
module wb_upsizer16_tb_top;
  localparam int unsigned AW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:1] mAdr;
  logic [15:0]   mDatW, mDatR;
  logic [1:0]    mSel;
  logic          mWe, mCyc, mStb, mAck, mErr;
  logic [AW-1:0] sAdr;
  logic [31:0]   sDatW, sDatR;
  logic [3:0]    sSel;
  logic          sWe, sCyc, sStb, sAck, sErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wb_upsizer16 #(.AW(AW)) dut_i (.*);

  function automatic logic [AW-1:0] expAdr(logic [AW-1:1] a);
    return {a[AW-1:2], 2'b00};
  endfunction
  function automatic logic [3:0] expSel(logic hi, logic [1:0] s);
    return hi ? {s, 2'b00} : {2'b00, s};
  endfunction
  function automatic logic [15:0] expRd(logic hi, logic [31:0] d);
    return hi ? d[31:16] : d[15:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [AW-1:1] a, logic [15:0] dw, logic [1:0] s, logic we,
                       logic cyc, logic stb, logic [31:0] dr, logic ack, logic err);
    @(posedge clk);
    #1;
    mAdr = a; mDatW = dw; mSel = s; mWe = we; mCyc = cyc; mStb = stb;
    sDatR = dr; sAck = ack; sErr = err;
    #2;
    chk("R1", 64'(sAdr), 64'(expAdr(a)));
    chk("R2", 64'(sDatW), 64'({dw, dw}));
    chk("R3", 64'(sSel), 64'(expSel(a[1], s)));
    chk("R4", 64'(mDatR), 64'(expRd(a[1], dr)));
    chk("R5", 64'({sCyc, sStb, sWe}), 64'({cyc, stb, we}));
    chk("R6", 64'({mAck, mErr}), 64'({ack, err}));
    chk("R7", 64'((|sSel[3:2]) && (|sSel[1:0])), 64'(0));
  endtask

  initial begin
    void'($urandom(32'd1234));
    // idle bus after start: nothing requested, nothing enabled
    apply('0, 16'h0, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    chk("R5", 64'({sCyc, sStb}), 64'(0));
    // directed: lower half write, full mask
    apply({30'h1234567, 1'b0}, 16'hA5C3, 2'b11, 1'b1, 1'b1, 1'b1, 32'hDEADBEEF, 1'b1, 1'b0);
    // directed: upper half write, full mask
    apply({30'h1234567, 1'b1}, 16'h5A3C, 2'b11, 1'b1, 1'b1, 1'b1, 32'hDEADBEEF, 1'b1, 1'b0);
    // directed: single byte lanes in each half (R3 lane order)
    apply({30'h3FFFFFFF, 1'b1}, 16'h00FF, 2'b01, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    apply({30'h0, 1'b0}, 16'hFF00, 2'b10, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    // directed reads of both halves
    apply({30'h15, 1'b0}, 16'h0, 2'b11, 1'b0, 1'b1, 1'b1, 32'h8765_4321, 1'b1, 1'b0);
    apply({30'h15, 1'b1}, 16'h0, 2'b11, 1'b0, 1'b1, 1'b1, 32'h8765_4321, 1'b1, 1'b0);
    // error without ack (R6)
    apply({30'h2A, 1'b1}, 16'h0, 2'b11, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      apply(31'($urandom), 16'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), $urandom, 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule